// File: doc/BRIEF.md
# Board Control Register Block

This block is a memory-mapped board controller attached to a simple 32-bit read/write bus. Only the low 20 address bits are decoded, so the block answers everywhere inside a 1 MiB window and repeats through the rest of the address space. It holds an 8-bit LED bar, an eight-character text display buffer, a break register and a general-purpose output register. It also provides a bit-bang I2C register set whose output register drives the clock and data pins toward an external I2C slave. A write of one key value to the soft-reset register raises a one-cycle system reset request.

The display buffer accepts one character per write at its own offset. It can also be filled in a single write to the word register, which turns a 32-bit value into eight uppercase hexadecimal characters. The switch, jumper and status registers are fixed read-only constants. Unmapped offsets read as zero and ignore writes.

Writes are taken on the rising clock edge in which `bus_valid` and `bus_we` are both high. Read data is combinational from the current address and the stored state.

Top module: `brdctl_top`

## Requirements
- R1: After reset the block holds LED 0x00, break 0x0A, GP output 0x00, I2C output enable 0x0, I2C output 0x3 (clock pin 1, data pin 1) and I2C select 0x1. All display characters are 0x20, the stored I2C input value is 0x3 and the reset request is low.
- R2: Only address bits 19:0 are decoded, so an address differing from an offset only in bits 31:20 reaches the same register.
- R3: A write to offset 0x408 stores the low 8 bits on the LED output, and a read of 0x408 returns that value zero-extended. No other write changes the LEDs.
- R4: A write to offset 0x410 sets all eight display characters to the value's hex digits in uppercase ASCII ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46). Character 0 receives bits 31:28 and character 7 receives bits 3:0. Character i sits on display output bits 8i+7:8i.
- R5: A write to offset 0x418 + 8·i, for i from 0 to 7, stores the low byte of the data into character i only.
- R6: A write of exactly 0x00000042 to offset 0x500 drives the reset request high for the one cycle after the write edge. Any other value written there gives no pulse.
- R7: Writes keep only part of the data: break (0x508) and GP output (0xA00) keep 8 bits, I2C output enable (0xB08) keeps 2 bits and I2C select (0xB18) keeps 1 bit. Each reads back the stored value.
- R8: The I2C output register (0xB10) stores all 32 bits and reads them back. Bit 1 drives the clock pin and bit 0 drives the data pin.
- R9: A read of the I2C input register (0xB00) returns the stored input value with bit 0 replaced by the data line from the slave, giving 0x2 or 0x3.
- R10: A read of the GP input register (0xA08) returns the I2C output register when I2C select is 1, and 0 when it is 0.
- R11: The switch (0x200) and jumper (0x210) registers read 0. The status register (0x208) reads 0x10, or 0x12 when BIG_ENDIAN is set. Writes to these three and to unmapped offsets change no state, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 32 | Byte address; bits 19:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| i2c_sda_i | input | 1 | Data line as seen from the slave |
| led_o | output | 8 | LED bar state |
| disp_o | output | 64 | Display characters, character i in bits 8i+7:8i |
| brk_o | output | 8 | Break register |
| gpo_o | output | 8 | General-purpose output register |
| i2c_oe_o | output | 2 | I2C output enable register |
| i2c_scl_o | output | 1 | I2C clock pin drive |
| i2c_sda_o | output | 1 | I2C data pin drive |
| srst_o | output | 1 | One-cycle system reset request |

## Verification
Every stored value and output pin changes at the clock edge that samples the write. The reset request is high during the cycle after that edge and low one cycle later. Read data is valid in the same cycle as the address, whether it comes from a register, the slave's data line or a constant. The bench drives each access on a falling edge and checks outputs on the next falling edge, one full register stage later. It checks read data 1 ns after presenting the address, and samples the reset request in both the cycle after the key write and the cycle after that.

// File: rtl/brdctl_pkg.sv
package brdctl_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int DEC_W  = 20;
    localparam int CHAR_W = 8;
    localparam int NCHAR  = DATA_W / 4;
    localparam int IDX_W  = $clog2(NCHAR);
    localparam int BYTE_W = 8;

    localparam logic [DEC_W-1:0] OFF_SWITCH = 20'h00200;
    localparam logic [DEC_W-1:0] OFF_STATUS = 20'h00208;
    localparam logic [DEC_W-1:0] OFF_JUMPER = 20'h00210;
    localparam logic [DEC_W-1:0] OFF_LED    = 20'h00408;
    localparam logic [DEC_W-1:0] OFF_WORD   = 20'h00410;
    localparam logic [DEC_W-1:0] OFF_CHAR0  = 20'h00418;
    localparam logic [DEC_W-1:0] OFF_CHAR7  = 20'h00450;
    localparam logic [DEC_W-1:0] OFF_SRST   = 20'h00500;
    localparam logic [DEC_W-1:0] OFF_BRK    = 20'h00508;
    localparam logic [DEC_W-1:0] OFF_GPO    = 20'h00A00;
    localparam logic [DEC_W-1:0] OFF_GPI    = 20'h00A08;
    localparam logic [DEC_W-1:0] OFF_I2CIN  = 20'h00B00;
    localparam logic [DEC_W-1:0] OFF_I2COE  = 20'h00B08;
    localparam logic [DEC_W-1:0] OFF_I2COUT = 20'h00B10;
    localparam logic [DEC_W-1:0] OFF_I2CSEL = 20'h00B18;

    localparam logic [DATA_W-1:0] SRST_KEY     = 32'h0000_0042;
    localparam logic [BYTE_W-1:0] BRK_RST      = 8'h0A;
    localparam logic [DATA_W-1:0] I2C_OUT_RST  = 32'h0000_0003;
    localparam logic [DATA_W-1:0] I2C_IN_RST   = 32'h0000_0003;
    localparam logic [CHAR_W-1:0] BLANK_CHAR   = 8'h20;
    localparam logic [DATA_W-1:0] STATUS_LE    = 32'h0000_0010;
    localparam logic [DATA_W-1:0] STATUS_BE    = 32'h0000_0012;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SWITCH,
        SEL_STATUS,
        SEL_JUMPER,
        SEL_LED,
        SEL_WORD,
        SEL_CHAR,
        SEL_SRST,
        SEL_BRK,
        SEL_GPO,
        SEL_GPI,
        SEL_I2CIN,
        SEL_I2COE,
        SEL_I2COUT,
        SEL_I2CSEL
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic logic [CHAR_W-1:0] hex_char(input logic [3:0] nib);
        if (nib < 4'd10) return 8'h30 + {4'h0, nib};
        else             return 8'h37 + {4'h0, nib};
    endfunction

endpackage

// File: rtl/brdctl_dec.sv
module brdctl_dec
    import brdctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [DEC_W-1:0] off;
    logic             unused_hi;

    assign off       = addr[DEC_W-1:0];
    assign unused_hi = ^addr[ADDR_W-1:DEC_W];

    always_comb begin
        dec.idx = off[IDX_W+2:3] - IDX_W'(OFF_CHAR0 >> 3);
        dec.sel = SEL_NONE;
        case (off)
            OFF_SWITCH: dec.sel = SEL_SWITCH;
            OFF_STATUS: dec.sel = SEL_STATUS;
            OFF_JUMPER: dec.sel = SEL_JUMPER;
            OFF_LED:    dec.sel = SEL_LED;
            OFF_WORD:   dec.sel = SEL_WORD;
            OFF_SRST:   dec.sel = SEL_SRST;
            OFF_BRK:    dec.sel = SEL_BRK;
            OFF_GPO:    dec.sel = SEL_GPO;
            OFF_GPI:    dec.sel = SEL_GPI;
            OFF_I2CIN:  dec.sel = SEL_I2CIN;
            OFF_I2COE:  dec.sel = SEL_I2COE;
            OFF_I2COUT: dec.sel = SEL_I2COUT;
            OFF_I2CSEL: dec.sel = SEL_I2CSEL;
            default: begin
                if (off >= OFF_CHAR0 && off <= OFF_CHAR7 && off[2:0] == 3'b000)
                    dec.sel = SEL_CHAR;
            end
        endcase
    end
endmodule

// File: rtl/brdctl_disp.sv
module brdctl_disp
    import brdctl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_word,
    input  logic                    wr_char,
    input  logic [IDX_W-1:0]        idx,
    input  logic [DATA_W-1:0]       wdata,
    output logic [NCHAR*CHAR_W-1:0] disp
);
    for (genvar i = 0; i < NCHAR; i++) begin : g_char
        localparam int MSB = DATA_W - 1 - 4 * i;
        always_ff @(posedge clk) begin
            if (rst) begin
                disp[i*CHAR_W +: CHAR_W] <= BLANK_CHAR;
            end else if (wr_word) begin
                disp[i*CHAR_W +: CHAR_W] <= hex_char(wdata[MSB -: 4]);
            end else if (wr_char && idx == IDX_W'(i)) begin
                disp[i*CHAR_W +: CHAR_W] <= wdata[CHAR_W-1:0];
            end
        end
    end
endmodule

// File: rtl/brdctl_regs.sv
module brdctl_regs
    import brdctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  sel_e              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [BYTE_W-1:0] led,
    output logic [BYTE_W-1:0] brk,
    output logic [BYTE_W-1:0] gpo,
    output logic [1:0]        i2c_oe,
    output logic [DATA_W-1:0] i2c_out,
    output logic              i2c_sel,
    output logic              srst
);
    always_ff @(posedge clk) begin
        if (rst) begin
            led     <= '0;
            brk     <= BRK_RST;
            gpo     <= '0;
            i2c_oe  <= '0;
            i2c_out <= I2C_OUT_RST;
            i2c_sel <= 1'b1;
            srst    <= 1'b0;
        end else begin
            srst <= 1'b0;
            if (we) begin
                case (sel)
                    SEL_LED:    led     <= wdata[BYTE_W-1:0];
                    SEL_BRK:    brk     <= wdata[BYTE_W-1:0];
                    SEL_GPO:    gpo     <= wdata[BYTE_W-1:0];
                    SEL_I2COE:  i2c_oe  <= wdata[1:0];
                    SEL_I2COUT: i2c_out <= wdata;
                    SEL_I2CSEL: i2c_sel <= wdata[0];
                    SEL_SRST:   srst    <= (wdata == SRST_KEY);
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/brdctl_top.sv
module brdctl_top
    import brdctl_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_valid,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic                    i2c_sda_i,
    output logic [BYTE_W-1:0]       led_o,
    output logic [NCHAR*CHAR_W-1:0] disp_o,
    output logic [BYTE_W-1:0]       brk_o,
    output logic [BYTE_W-1:0]       gpo_o,
    output logic [1:0]              i2c_oe_o,
    output logic                    i2c_scl_o,
    output logic                    i2c_sda_o,
    output logic                    srst_o
);
    localparam logic [DATA_W-1:0] STATUS_VAL = BIG_ENDIAN ? STATUS_BE : STATUS_LE;

    dec_t              dec;
    logic              wr;
    logic [DATA_W-1:0] i2c_out;
    logic              i2c_sel;

    assign wr = bus_valid && bus_we;

    brdctl_dec dec_i (
        .addr (bus_addr),
        .dec  (dec)
    );

    brdctl_disp disp_i (
        .clk     (clk),
        .rst     (rst),
        .wr_word (wr && dec.sel == SEL_WORD),
        .wr_char (wr && dec.sel == SEL_CHAR),
        .idx     (dec.idx),
        .wdata   (bus_wdata),
        .disp    (disp_o)
    );

    brdctl_regs regs_i (
        .clk     (clk),
        .rst     (rst),
        .we      (wr),
        .sel     (dec.sel),
        .wdata   (bus_wdata),
        .led     (led_o),
        .brk     (brk_o),
        .gpo     (gpo_o),
        .i2c_oe  (i2c_oe_o),
        .i2c_out (i2c_out),
        .i2c_sel (i2c_sel),
        .srst    (srst_o)
    );

    assign i2c_scl_o = i2c_out[1];
    assign i2c_sda_o = i2c_out[0];

    always_comb begin
        case (dec.sel)
            SEL_STATUS: bus_rdata = STATUS_VAL;
            SEL_LED:    bus_rdata = DATA_W'(led_o);
            SEL_BRK:    bus_rdata = DATA_W'(brk_o);
            SEL_GPO:    bus_rdata = DATA_W'(gpo_o);
            SEL_GPI:    bus_rdata = i2c_sel ? i2c_out : '0;
            SEL_I2CIN:  bus_rdata = {I2C_IN_RST[DATA_W-1:1], i2c_sda_i};
            SEL_I2COE:  bus_rdata = DATA_W'(i2c_oe_o);
            SEL_I2COUT: bus_rdata = i2c_out;
            SEL_I2CSEL: bus_rdata = DATA_W'(i2c_sel);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/brdctl_chk.sv
module brdctl_chk
    import brdctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [BYTE_W-1:0] led_o,
    input logic [1:0]        i2c_oe_o,
    input logic              srst_o
);
    logic [DEC_W-1:0] off;
    logic             wr;
    logic             unused_hi;

    assign off       = bus_addr[DEC_W-1:0];
    assign wr        = bus_valid && bus_we;
    assign unused_hi = ^bus_addr[ADDR_W-1:DEC_W];

    p_srst_fire_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && off == OFF_SRST && bus_wdata == SRST_KEY) |=> srst_o);

    p_srst_cause_r6: assert property (@(posedge clk) disable iff (rst)
        srst_o |-> $past(wr && off == OFF_SRST && bus_wdata == SRST_KEY));

    p_led_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && off == OFF_LED) |=> led_o == $past(bus_wdata[BYTE_W-1:0]));

    p_led_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr && off == OFF_LED) |=> $stable(led_o));

    p_oe_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (wr && off == OFF_I2COE) |=> i2c_oe_o == $past(bus_wdata[1:0]));

    p_switch_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (off == OFF_SWITCH || off == OFF_JUMPER) |-> bus_rdata == '0);
endmodule

bind brdctl_top brdctl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .led_o     (led_o),
    .i2c_oe_o  (i2c_oe_o),
    .srst_o    (srst_o)
);

// File: tb/brdctl_top_tb_top.sv
`timescale 1ns/1ps
module brdctl_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        i2c_sda_i = 1'b1;
    logic [7:0]  led_o;
    logic [63:0] disp_o;
    logic [7:0]  brk_o;
    logic [7:0]  gpo_o;
    logic [1:0]  i2c_oe_o;
    logic        i2c_scl_o;
    logic        i2c_sda_o;
    logic        srst_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    brdctl_top dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .i2c_sda_i(i2c_sda_i), .led_o(led_o), .disp_o(disp_o), .brk_o(brk_o),
        .gpo_o(gpo_o), .i2c_oe_o(i2c_oe_o), .i2c_scl_o(i2c_scl_o),
        .i2c_sda_o(i2c_sda_o), .srst_o(srst_o)
    );

    typedef struct packed {
        logic [31:0] wa;
        logic [31:0] wd;
        logic [31:0] ra;
        logic [31:0] ex;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0408, 32'h1234_56A5, 32'h0000_0408, 32'h0000_00A5}, // R3
        '{32'hFFF0_0408, 32'h0000_003C, 32'h1F10_0408, 32'h0000_003C}, // R2
        '{32'h0000_0508, 32'hFFFF_FF77, 32'h0000_0508, 32'h0000_0077}, // R7
        '{32'h0000_0A00, 32'h0000_01FF, 32'h0000_0A00, 32'h0000_00FF}, // R7
        '{32'h0000_0B08, 32'h0000_00FF, 32'h0000_0B08, 32'h0000_0003}, // R7
        '{32'h0000_0B18, 32'h0000_00FE, 32'h0000_0B18, 32'h0000_0000}, // R7
        '{32'h0000_0B10, 32'hDEAD_BEE2, 32'h0000_0A08, 32'h0000_0000}, // R10
        '{32'h0000_0B18, 32'h0000_0001, 32'h0000_0A08, 32'hDEAD_BEE2}, // R10
        '{32'h0000_0B10, 32'h0000_0005, 32'h0000_0B10, 32'h0000_0005}, // R8
        '{32'h0000_0200, 32'h0000_FFFF, 32'h0000_0200, 32'h0000_0000}, // R11
        '{32'h0000_0210, 32'h0000_0007, 32'h0000_0210, 32'h0000_0000}, // R11
        '{32'h0000_0208, 32'h0000_00AA, 32'h0000_0208, 32'h0000_0010}, // R11
        '{32'h0000_0300, 32'h0000_0055, 32'h0000_0300, 32'h0000_0000}, // R11
        '{32'h0000_0404, 32'h0000_0011, 32'h0000_0408, 32'h0000_003C}  // R11
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0; bus_addr = 32'h0000_0300;
        #1;
    endtask

    task automatic rd(input string tag, input logic [31:0] a, input logic [31:0] exp);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        chk(tag, {32'h0, bus_rdata}, {32'h0, exp});
        bus_valid = 1'b0;
    endtask

    function automatic logic [7:0] hx(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h41 + {4'h0, n} - 8'd10);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        logic [63:0] exp_disp;
        logic [31:0] word;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 led", {56'h0, led_o}, 64'h0);
        chk("R1 disp", disp_o, 64'h2020_2020_2020_2020);
        chk("R1 brk", {56'h0, brk_o}, 64'h0A);
        chk("R1 gpo", {56'h0, gpo_o}, 64'h0);
        chk("R1 oe", {62'h0, i2c_oe_o}, 64'h0);
        chk("R1 pins", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h3);
        chk("R1 srst", {63'h0, srst_o}, 64'h0);
        rd("R1 sel", 32'h0000_0B18, 32'h1);
        rd("R1 i2cout", 32'h0000_0B10, 32'h3);
        rd("R1 gpi", 32'h0000_0A08, 32'h3);
        rd("R1 i2cin", 32'h0000_0B00, 32'h3);

        for (int v = 0; v < NV; v++) begin
            wr(VEC[v].wa, VEC[v].wd);
            rd($sformatf("vector %0d", v), VEC[v].ra, VEC[v].ex);
        end

        // R8 pins from output register (holds 0x5)
        chk("R8 pins a", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h1);
        wr(32'h0000_0B10, 32'h0000_0002);
        chk("R8 pins b", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h2);
        chk("R3 led unchanged", {56'h0, led_o}, 64'h3C);

        // R9 input register follows slave data line
        i2c_sda_i = 1'b0;
        rd("R9 sda0", 32'h0000_0B00, 32'h2);
        i2c_sda_i = 1'b1;
        rd("R9 sda1", 32'h0040_0B00, 32'h3);

        // R4 word write
        word = 32'h0123_ABCF;
        wr(32'h0000_0410, word);
        for (int i = 0; i < 8; i++) exp_disp[i*8 +: 8] = hx(word[31-4*i -: 4]);
        chk("R4 hex word", disp_o, exp_disp);
        word = 32'hFEDC_9870;
        wr(32'hABC0_0410, word);
        for (int i = 0; i < 8; i++) exp_disp[i*8 +: 8] = hx(word[31-4*i -: 4]);
        chk("R4 hex word alias", disp_o, exp_disp);

        // R5 character writes
        wr(32'h0000_0450, 32'h0000_017A);
        exp_disp[63:56] = 8'h7A;
        chk("R5 char7", disp_o, exp_disp);
        wr(32'h0000_0418, 32'h0000_0041);
        exp_disp[7:0] = 8'h41;
        chk("R5 char0", disp_o, exp_disp);
        wr(32'h0000_0430, 32'h0000_0023);
        exp_disp[31:24] = 8'h23;
        chk("R5 char3", disp_o, exp_disp);
        wr(32'h0000_041C, 32'h0000_0055);
        chk("R11 unaligned char", disp_o, exp_disp);

        // R6 soft reset
        wr(32'h0000_0500, 32'h0000_0041);
        chk("R6 wrong key", {63'h0, srst_o}, 64'h0);
        wr(32'h0000_0500, 32'h0000_0142);
        chk("R6 wide key", {63'h0, srst_o}, 64'h0);
        wr(32'h0000_0500, 32'h0000_0042);
        chk("R6 pulse", {63'h0, srst_o}, 64'h1);
        @(negedge clk); #1;
        chk("R6 pulse end", {63'h0, srst_o}, 64'h0);
        chk("R6 no side effect", {56'h0, led_o}, 64'h3C);

        done = 1'b1;
        summary();
    end
endmodule